// File: doc/BRIEF.md
# AES-128 Block Decryptor with Stored Round-Key Schedule

This block turns 128-bit AES ciphertext blocks back into plaintext under a 128-bit cipher key. Key handling is kept apart from block processing. The caller first captures a key with a one-clock strobe. It then holds a key-calculate input high while the forward key expansion produces the ten further round keys, one per clock. All eleven round keys are kept in an internal register file, and a key-done flag reports that the schedule is complete.

Once the schedule is valid it serves any number of blocks with no further expansion and no reset. For each block the caller captures the ciphertext with a one-clock strobe, then holds the decrypt-calculate input high. The block first adds round key 10, then runs ten inverse rounds using the keys in descending order. A decrypt-done flag then marks the plaintext as valid. The two handshakes are interlocked: a block cannot run without a complete schedule, and capturing a new key throws away any block in progress.

Top module: `aes128_dec_keystore`

## Requirements
- R1: `rst` is asynchronous and active high. While it is high, `key_done`, `dec_done` and `pt_out` are zero, and the stored key, schedule and block are discarded.
- R2: A clock with `key_load` high captures `key_in` and clears `key_done` and `dec_done` on that edge.
- R3: Expansion advances one round key on each clock where `key_calc` is high, a key has been captured and the schedule is not yet complete. `key_done` rises after the 10th such clock, counting across pauses in `key_calc`. It stays high until the next `key_load` or reset.
- R4: A clock with `data_load` high (and `key_load` low) captures `ct_in`, clears `dec_done` and restarts the block from its first step.
- R5: With `key_done` high and a block captured, each clock with `dec_calc` high performs one step. `dec_done` rises after the 11th step, so it reads high 11 clocks after `dec_calc` is raised.
- R6: `dec_calc` has no effect while `key_done` is low, whether no key has been expanded since reset or a key was loaded and not yet expanded. `dec_done` stays low.
- R7: Step 0 adds round key 10. Steps 1 to 9 each apply inverse row shift, inverse byte substitution, key addition with keys 9 down to 1, and inverse column mixing. Step 10 omits the column mixing and adds key 0. `pt_out` then equals standard AES-128 decryption, with byte 0 of each 128-bit bus at bits [127:120].
- R8: `key_load` while a block is in flight or finished discards that block. `dec_done` stays low until a new `data_load` and a new run after `key_done`, even if `dec_calc` stays high.
- R9: A single expansion serves any number of consecutive blocks with no reset and no new expansion.
- R10: While `dec_done` is high and neither load strobe is active, `pt_out` and `dec_done` hold, even if `dec_calc` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| key_load | input | 1 | One-clock strobe capturing `key_in` |
| key_calc | input | 1 | Held high to run the key expansion |
| key_in | input | 128 | Cipher key, byte 0 at [127:120] |
| data_load | input | 1 | One-clock strobe capturing `ct_in` |
| dec_calc | input | 1 | Held high to run the decryption |
| ct_in | input | 128 | Ciphertext block, byte 0 at [127:120] |
| key_done | output | 1 | Round-key schedule complete and valid |
| dec_done | output | 1 | Plaintext on `pt_out` is valid |
| pt_out | output | 128 | Plaintext block, byte 0 at [127:120] |

## Verification
A wrong round-key entry, a reversed key order or a missed column-mixing skip stays hidden until the end of the block. It then shows as a wrong `pt_out` exactly 11 clocks after `dec_calc` rises, so every block is compared against an independently computed encryption. A stale schedule-valid flag or a miscounted expansion shows sooner, as `key_done` rising one clock early or late, or as `dec_done` rising after a fresh key load. The bench therefore samples both flags on the exact clock where they must change, and on the clocks just before.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;

  localparam int AES_NR    = 10;
  localparam int AES_BLK_W = 128;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = gf_xtime(x);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] x;
    r = 8'h01;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, x);
      x = gf_mul(x, x);
    end
    return r;
  endfunction

  function automatic logic [7:0] rot8(input logic [7:0] a, input int n);
    logic [15:0] d;
    d = {a, a} << n;
    return d[15:8];
  endfunction

  function automatic logic [7:0] sub_fwd(input logic [7:0] a);
    logic [7:0] x;
    x = gf_inv(a);
    return x ^ rot8(x, 1) ^ rot8(x, 2) ^ rot8(x, 3) ^ rot8(x, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sub_inv(input logic [7:0] a);
    logic [7:0] y;
    y = rot8(a, 1) ^ rot8(a, 3) ^ rot8(a, 6) ^ 8'h05;
    return gf_inv(y);
  endfunction

  function automatic logic [7:0] rcon_of(input logic [3:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < AES_NR; i++)
      if (i < int'(idx)) r = gf_xtime(r);
    return r;
  endfunction

  function automatic logic [7:0] blk_byte(input logic [127:0] s, input int i);
    return s[127-8*i -: 8];
  endfunction

  // row r of column c sits at byte r + 4c
  function automatic logic [127:0] inv_rows(input logic [127:0] s);
    logic [127:0] o;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(r+4*c) -: 8] = blk_byte(s, r + 4*((c - r + 4) % 4));
    return o;
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] col);
    logic [7:0] a0, a1, a2, a3;
    a0 = col[31:24]; a1 = col[23:16]; a2 = col[15:8]; a3 = col[7:0];
    return {gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09),
            gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d),
            gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b),
            gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e)};
  endfunction

  // one forward expansion step: round key idx -> idx+1
  function automatic logic [127:0] key_next(input logic [127:0] k, input logic [3:0] idx);
    logic [31:0] t, w0, w1, w2, w3;
    t  = {sub_fwd(k[23:16]), sub_fwd(k[15:8]), sub_fwd(k[7:0]), sub_fwd(k[31:24])};
    t  = t ^ {rcon_of(idx), 24'h0};
    w0 = k[127:96] ^ t;
    w1 = k[95:64]  ^ w0;
    w2 = k[63:32]  ^ w1;
    w3 = k[31:0]   ^ w2;
    return {w0, w1, w2, w3};
  endfunction

endpackage

// File: rtl/aes_dec_keysched.sv
module aes_dec_keysched
  import aes_dec_pkg::*;
#(
  parameter int NR    = AES_NR,
  parameter int BLK_W = AES_BLK_W,
  localparam int IW   = $clog2(NR + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_load,
  input  logic             key_calc,
  input  logic [BLK_W-1:0] key_in,
  input  logic [IW-1:0]    rd_idx,
  output logic [BLK_W-1:0] rd_key,
  output logic             sched_valid,
  output logic             exp_fire
);

  logic [BLK_W-1:0] rk_q [NR+1];
  logic [IW-1:0]    widx_q;
  logic             have_key_q;
  logic             valid_q;
  logic [BLK_W-1:0] nxt_key;

  assign exp_fire = key_calc && have_key_q && !valid_q && !key_load;
  assign nxt_key  = key_next(rk_q[widx_q], 4'(widx_q));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      widx_q     <= '0;
      have_key_q <= 1'b0;
      valid_q    <= 1'b0;
    end else if (key_load) begin
      widx_q     <= '0;
      have_key_q <= 1'b1;
      valid_q    <= 1'b0;
    end else if (exp_fire) begin
      widx_q <= widx_q + 1'b1;
      if (widx_q == IW'(NR - 1)) valid_q <= 1'b1;
    end
  end

  // one storage row per round key
  for (genvar g = 0; g <= NR; g++) begin : g_rk
    if (g == 0) begin : g_base
      always_ff @(posedge clk or posedge rst) begin
        if (rst)           rk_q[g] <= '0;
        else if (key_load) rk_q[g] <= key_in;
      end
    end else begin : g_exp
      always_ff @(posedge clk or posedge rst) begin
        if (rst)                                      rk_q[g] <= '0;
        else if (exp_fire && widx_q == IW'(g - 1))    rk_q[g] <= nxt_key;
      end
    end
  end

  assign rd_key      = (int'(rd_idx) <= NR) ? rk_q[rd_idx] : '0;
  assign sched_valid = valid_q;

endmodule

// File: rtl/aes_dec_round.sv
module aes_dec_round
  import aes_dec_pkg::*;
#(
  parameter int BLK_W = AES_BLK_W
) (
  input  logic [BLK_W-1:0] st_in,
  input  logic [BLK_W-1:0] rkey,
  input  logic             first_step,
  input  logic             last_step,
  output logic [BLK_W-1:0] st_out
);

  logic [BLK_W-1:0] shifted;
  logic [BLK_W-1:0] subbed;
  logic [BLK_W-1:0] keyed;
  logic [BLK_W-1:0] mixed;

  assign shifted = inv_rows(st_in);

  for (genvar b = 0; b < BLK_W / 8; b++) begin : g_sub
    assign subbed[BLK_W-1-8*b -: 8] = sub_inv(shifted[BLK_W-1-8*b -: 8]);
  end

  assign keyed = subbed ^ rkey;

  for (genvar c = 0; c < BLK_W / 32; c++) begin : g_mix
    assign mixed[BLK_W-1-32*c -: 32] = inv_mix_col(keyed[BLK_W-1-32*c -: 32]);
  end

  always_comb begin
    if (first_step)     st_out = st_in ^ rkey;
    else if (last_step) st_out = keyed;
    else                st_out = mixed;
  end

endmodule

// File: rtl/aes_dec_datapath.sv
module aes_dec_datapath
  import aes_dec_pkg::*;
#(
  parameter int NR    = AES_NR,
  parameter int BLK_W = AES_BLK_W,
  localparam int IW   = $clog2(NR + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_load,
  input  logic             data_load,
  input  logic             dec_calc,
  input  logic [BLK_W-1:0] ct_in,
  input  logic             sched_valid,
  input  logic [BLK_W-1:0] rkey,
  output logic [IW-1:0]    rd_idx,
  output logic             step_fire,
  output logic             dec_done,
  output logic [BLK_W-1:0] pt_out
);

  logic [BLK_W-1:0] st_q;
  logic [IW-1:0]    step_q;
  logic             blk_q;
  logic             done_q;
  logic [BLK_W-1:0] st_nxt;

  assign step_fire = dec_calc && sched_valid && blk_q && !done_q && !key_load && !data_load;
  assign rd_idx    = (int'(step_q) <= NR) ? IW'(NR) - step_q : '0;

  aes_dec_round #(.BLK_W(BLK_W)) u_round (
    .st_in      (st_q),
    .rkey       (rkey),
    .first_step (step_q == '0),
    .last_step  (step_q == IW'(NR)),
    .st_out     (st_nxt)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st_q   <= '0;
      step_q <= '0;
      blk_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (key_load) begin
      step_q <= '0;
      blk_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (data_load) begin
      st_q   <= ct_in;
      step_q <= '0;
      blk_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (step_fire) begin
      st_q   <= st_nxt;
      step_q <= step_q + 1'b1;
      if (step_q == IW'(NR)) done_q <= 1'b1;
    end
  end

  assign dec_done = done_q;
  assign pt_out   = st_q;

endmodule

// File: rtl/aes128_dec_keystore.sv
module aes128_dec_keystore
  import aes_dec_pkg::*;
#(
  parameter int NR    = AES_NR,
  parameter int BLK_W = AES_BLK_W,
  localparam int IW   = $clog2(NR + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_load,
  input  logic             key_calc,
  input  logic [BLK_W-1:0] key_in,
  input  logic             data_load,
  input  logic             dec_calc,
  input  logic [BLK_W-1:0] ct_in,
  output logic             key_done,
  output logic             dec_done,
  output logic [BLK_W-1:0] pt_out
);

  // internal events brought out for the checker
  logic             exp_fire;
  logic             step_fire;
  logic             sched_valid;
  logic [IW-1:0]    rd_idx;
  logic [BLK_W-1:0] rkey;

  aes_dec_keysched #(.NR(NR), .BLK_W(BLK_W)) u_keys (
    .clk         (clk),
    .rst         (rst),
    .key_load    (key_load),
    .key_calc    (key_calc),
    .key_in      (key_in),
    .rd_idx      (rd_idx),
    .rd_key      (rkey),
    .sched_valid (sched_valid),
    .exp_fire    (exp_fire)
  );

  aes_dec_datapath #(.NR(NR), .BLK_W(BLK_W)) u_data (
    .clk         (clk),
    .rst         (rst),
    .key_load    (key_load),
    .data_load   (data_load),
    .dec_calc    (dec_calc),
    .ct_in       (ct_in),
    .sched_valid (sched_valid),
    .rkey        (rkey),
    .rd_idx      (rd_idx),
    .step_fire   (step_fire),
    .dec_done    (dec_done),
    .pt_out      (pt_out)
  );

  assign key_done = sched_valid;

endmodule

// File: rtl/aes_dec_checker.sv
module aes_dec_checker #(
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             key_load,
  input logic             key_calc,
  input logic             data_load,
  input logic             dec_calc,
  input logic             key_done,
  input logic             dec_done,
  input logic [BLK_W-1:0] pt_out,
  input logic             exp_fire,
  input logic             step_fire
);

  p_keyload_clears_r2: assert property (@(posedge clk) disable iff (rst)
    key_load |=> (!key_done && !dec_done));

  p_keydone_needs_calc_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(key_done) |-> $past(key_calc));

  p_keydone_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (key_done && !key_load) |=> key_done);

  p_no_expand_when_valid_r3: assert property (@(posedge clk) disable iff (rst)
    exp_fire |-> !key_done);

  p_done_needs_calc_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_done) |-> $past(dec_calc));

  p_step_needs_sched_r6: assert property (@(posedge clk) disable iff (rst)
    step_fire |-> key_done);

  p_done_implies_key_r8: assert property (@(posedge clk) disable iff (rst)
    dec_done |-> key_done);

  p_no_step_during_expand_r8: assert property (@(posedge clk) disable iff (rst)
    !(step_fire && exp_fire));

  p_result_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (dec_done && !data_load && !key_load) |=> (dec_done && $stable(pt_out)));

endmodule

bind aes128_dec_keystore aes_dec_checker #(.BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .key_load  (key_load),
  .key_calc  (key_calc),
  .data_load (data_load),
  .dec_calc  (dec_calc),
  .key_done  (key_done),
  .dec_done  (dec_done),
  .pt_out    (pt_out),
  .exp_fire  (exp_fire),
  .step_fire (step_fire)
);

// File: tb/aes128_dec_keystore_tb.sv
`timescale 1ns/1ps
module aes128_dec_keystore_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         key_load = 1'b0, key_calc = 1'b0, data_load = 1'b0, dec_calc = 1'b0;
  logic [127:0] key_in = '0, ct_in = '0;
  logic         key_done, dec_done;
  logic [127:0] pt_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  aes128_dec_keystore u_dut (
    .clk(clk), .rst(rst), .key_load(key_load), .key_calc(key_calc), .key_in(key_in),
    .data_load(data_load), .dec_calc(dec_calc), .ct_in(ct_in),
    .key_done(key_done), .dec_done(dec_done), .pt_out(pt_out)
  );

  // ---------------- reference encryption (table built by generator walk)
  logic [7:0] sb [256];

  function automatic logic [7:0] m2(input logic [7:0] a);
    return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ m2(p);
      q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [127:0] ref_encrypt(input logic [127:0] key, input logic [127:0] pt);
    logic [31:0] w [44];
    logic [7:0]  s [16];
    logic [7:0]  t [16];
    logic [31:0] tmp;
    logic [7:0]  rc;
    logic [127:0] o;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {sb[tmp[23:16]] ^ rc, sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]};
        rc = m2(rc);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int i = 0; i < 16; i++) t[i] = sb[s[(i%4) + 4*(((i/4) + (i%4)) % 4)]];
      for (int c = 0; c < 4; c++) begin
        for (int r = 0; r < 4; r++) begin
          if (rnd == 10) s[4*c+r] = t[4*c+r];
          else s[4*c+r] = m2(t[4*c+r]) ^ m2(t[4*c+(r+1)%4]) ^ t[4*c+(r+1)%4]
                          ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*rnd + i/4][31-8*(i%4) -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  // ---------------- helpers
  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_key(input logic [127:0] k);
    @(negedge clk); key_load = 1'b1; key_in = k;
    @(negedge clk); key_load = 1'b0; key_calc = 1'b1;
    repeat (10) @(negedge clk);
    key_calc = 1'b0;
  endtask

  task automatic do_block(input logic [127:0] c, output logic [127:0] p, output logic d);
    @(negedge clk); data_load = 1'b1; ct_in = c;
    @(negedge clk); data_load = 1'b0; dec_calc = 1'b1;
    repeat (11) @(negedge clk);
    p = pt_out; d = dec_done;
    dec_calc = 1'b0;
  endtask

  // ---------------- scenarios
  task automatic t_reset();
    chk("R1", "key_done in reset", 128'(key_done), 128'h0);
    chk("R1", "dec_done in reset", 128'(dec_done), 128'h0);
    chk("R1", "pt_out in reset", pt_out, 128'h0);
  endtask

  task automatic t_no_key_ignored();
    // R6: block loaded, key captured but never expanded
    @(negedge clk); key_load = 1'b1; key_in = 128'h1;
    @(negedge clk); key_load = 1'b0; data_load = 1'b1; ct_in = 128'hdead;
    @(negedge clk); data_load = 1'b0; dec_calc = 1'b1;
    repeat (15) @(negedge clk);
    chk("R6", "dec_done without schedule", 128'(dec_done), 128'h0);
    chk("R6", "pt_out unchanged without schedule", pt_out, 128'hdead);
    dec_calc = 1'b0;
  endtask

  task automatic t_fips_timing();
    logic [127:0] p;
    logic d;
    @(negedge clk); key_load = 1'b1; key_in = 128'h000102030405060708090a0b0c0d0e0f;
    @(negedge clk); key_load = 1'b0;
    chk("R2", "key_done after load", 128'(key_done), 128'h0);
    key_calc = 1'b1;
    repeat (9) @(negedge clk);
    chk("R3", "key_done after 9 clocks", 128'(key_done), 128'h0);
    @(negedge clk);
    chk("R3", "key_done after 10 clocks", 128'(key_done), 128'h1);
    key_calc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3", "key_done held", 128'(key_done), 128'h1);
    @(negedge clk); data_load = 1'b1; ct_in = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    @(negedge clk); data_load = 1'b0; dec_calc = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5", "dec_done after 10 clocks", 128'(dec_done), 128'h0);
    @(negedge clk);
    chk("R5", "dec_done after 11 clocks", 128'(dec_done), 128'h1);
    chk("R7", "known vector plaintext", pt_out, 128'h00112233445566778899aabbccddeeff);
    p = pt_out;
    repeat (5) @(negedge clk);
    chk("R10", "result held with calc high", pt_out, p);
    chk("R10", "done held with calc high", 128'(dec_done), 128'h1);
    dec_calc = 1'b0;
    @(negedge clk); data_load = 1'b1; ct_in = 128'h5;
    @(negedge clk); data_load = 1'b0;
    chk("R4", "data_load clears done", 128'(dec_done), 128'h0);
    d = 1'b0;
    do_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a, p, d);
    chk("R4", "reloaded block decrypts", p, 128'h00112233445566778899aabbccddeeff);
  endtask

  task automatic t_reuse();
    logic [127:0] k, pt, ct, p;
    logic d;
    k = {$urandom, $urandom, $urandom, $urandom};
    do_key(k);
    for (int n = 0; n < 6; n++) begin
      pt = {$urandom, $urandom, $urandom, $urandom};
      if (n == 0) pt = '0;
      if (n == 1) pt = '1;
      ct = ref_encrypt(k, pt);
      do_block(ct, p, d);
      chk("R9", "reused schedule done", 128'(d), 128'h1);
      chk("R7", "reused schedule plaintext", p, pt);
    end
  endtask

  task automatic t_paused_expand();
    logic [127:0] k, pt, p;
    logic d;
    k = 128'hfedcba98765432100123456789abcdef;
    @(negedge clk); key_load = 1'b1; key_in = k;
    @(negedge clk); key_load = 1'b0; key_calc = 1'b1;
    repeat (4) @(negedge clk);
    key_calc = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3", "key_done low while paused", 128'(key_done), 128'h0);
    key_calc = 1'b1;
    repeat (5) @(negedge clk);
    chk("R3", "key_done after 9 calc clocks", 128'(key_done), 128'h0);
    @(negedge clk);
    chk("R3", "key_done after 10 calc clocks", 128'(key_done), 128'h1);
    key_calc = 1'b0;
    pt = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    do_block(ref_encrypt(k, pt), p, d);
    chk("R7", "plaintext after paused expansion", p, pt);
  endtask

  task automatic t_key_abort();
    logic [127:0] k2, pt, p;
    logic d;
    k2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    @(negedge clk); data_load = 1'b1; ct_in = 128'h1234;
    @(negedge clk); data_load = 1'b0; dec_calc = 1'b1;
    repeat (5) @(negedge clk);
    key_load = 1'b1; key_in = k2;
    @(negedge clk); key_load = 1'b0;
    chk("R2", "key_done cleared by load", 128'(key_done), 128'h0);
    chk("R8", "dec_done low after key load", 128'(dec_done), 128'h0);
    key_calc = 1'b1;
    repeat (10) @(negedge clk);
    key_calc = 1'b0;
    repeat (15) @(negedge clk);
    chk("R8", "discarded block never completes", 128'(dec_done), 128'h0);
    dec_calc = 1'b0;
    pt = 128'h6bc1bee22e409f96e93d7e117393172a;
    do_block(ref_encrypt(k2, pt), p, d);
    chk("R8", "new block under new key done", 128'(d), 128'h1);
    chk("R7", "new key plaintext", p, pt);
  endtask

  task automatic t_async_reset();
    @(negedge clk); key_load = 1'b1; key_in = 128'h77;
    @(negedge clk); key_load = 1'b0; key_calc = 1'b1;
    repeat (10) @(negedge clk);
    key_calc = 1'b0;
    @(negedge clk); data_load = 1'b1; ct_in = 128'h99;
    @(negedge clk); data_load = 1'b0;
    #1 rst = 1'b1;
    #0.5;
    chk("R1", "key_done cleared asynchronously", 128'(key_done), 128'h0);
    chk("R1", "pt_out cleared asynchronously", pt_out, 128'h0);
    @(negedge clk); rst = 1'b0;
    dec_calc = 1'b1;
    repeat (15) @(negedge clk);
    chk("R1", "no block after reset", 128'(dec_done), 128'h0);
    dec_calc = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_no_key_ignored();
    t_fips_timing();
    t_reuse();
    t_paused_expand();
    t_key_abort();
    t_async_reset();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule